// File: doc/BRIEF.md
# Dual-Bridge Fixed-Frequency Current-Chopping Controller

This block holds the digital timing for two H-bridges whose winding current is limited by chopping at a fixed frequency. One period counter is shared by the bridges. It issues a cycle-start pulse to bridge 0 when it reads zero, and a pulse to bridge 1 half a period later. With this offset the two bridges never begin conducting on the same clock. At each cycle start a bridge switches on its high-side (source) driver. A digital sense-comparator input ends that ON pulse. The controller ignores this input for a blanking window after every source turn-on, so the recovery spike cannot end the pulse too early. After a trip the source turns off. The opposite low-side (sink) driver stays on, so the current decays slowly until the next cycle start.

Each bridge has its own direction, enable and trip inputs. A single fault flag and a single sleep input act on both bridges. Any change of direction opens a dead-time window in which all four drivers of that bridge are off. The next turn-on of the source then starts a new blanking window. The dead time, the blanking time and the period are parameters given in clock cycles.

Each bridge runs a state machine with five states. OFF: all drivers off. DEAD: all drivers off while the dead time runs. BLANK: source and opposite sink on, trips ignored. DRIVE: source and opposite sink on, trips honoured. DECAY: only the opposite sink on. The transitions are:
- start: OFF to DEAD on a cycle start.
- dead_done: DEAD to BLANK when the dead time ends.
- blank_done: BLANK to DRIVE when the blanking time ends.
- trip: DRIVE to DECAY on a trip.
- restart: DECAY to BLANK on a cycle start.
- reverse: BLANK, DRIVE or DECAY to DEAD on a direction change.
- kill: any state to OFF on sleep, fault or enable low.

Top module: `chop_pwm_ctrl`

## Requirements
- R1: After reset, all eight gate outputs are low.
- R2: For each bridge, direction high drives source A with sink B, and direction low drives source B with sink A.
- R3: After a cycle start reaches a bridge in OFF, its outputs stay low for DEAD_CYC clocks, and its drivers turn on in the next clock.
- R4: The trip input has no effect during the blanking window. With trip held high from turn-on, the source stays on for exactly BLANK_CYC+1 clocks.
- R5: A trip sampled after blanking turns the source off one clock later, while the opposite sink stays on. In steady state, consecutive source turn-ons of a bridge are PERIOD_CYC clocks apart.
- R6: In the same period, bridge 1 turns its source on PERIOD_CYC/2 clocks after bridge 0.
- R7: Source and sink on the same side are never high together. A direction change turns all four drivers of the bridge off for DEAD_CYC clocks, then turns on the new direction with a new blanking window.
- R8: Enable low turns all four drivers of that bridge off one clock later and leaves the other bridge unchanged. After enable returns, drive waits for the bridge's next cycle start.
- R9: Fault high turns all outputs off one clock later. After fault clears, each bridge stays off until its own next cycle start.
- R10: Sleep high turns all outputs off one clock later and holds the period counter at zero. After sleep is released, bridge 0 turns on DEAD_CYC+1 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Stops both bridges and the period counter |
| fault_i | input | 1 | Fault flag; forces all drivers off |
| phase_i | input | NUM_BRIDGES | Direction per bridge |
| enable_i | input | NUM_BRIDGES | Bridge enable |
| trip_i | input | NUM_BRIDGES | Digital sense-comparator result |
| src_a_o | output | NUM_BRIDGES | Source driver, side A |
| snk_a_o | output | NUM_BRIDGES | Sink driver, side A |
| src_b_o | output | NUM_BRIDGES | Source driver, side B |
| snk_b_o | output | NUM_BRIDGES | Sink driver, side B |

## Verification
Chopping is tried three ways. With trip held high from turn-on, the bench measures the blanking length and sees the slow-decay sink stay on. A short trip pulse inside the blanking window must be ignored, while a later single-clock pulse must end the pulse after one clock; this separates masking from latency. A direction change during DRIVE checks the dead gap and the new blanking window in the reversed direction. Restarts after an enable drop, after a fault and after sleep each check that drive waits for the correct cycle start and that the half-period offset between the bridges still holds.

// File: rtl/chop_pwm_pkg.sv
package chop_pwm_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DEAD,
        ST_BLANK,
        ST_DRIVE,
        ST_DECAY
    } bridge_state_e;

    typedef struct packed {
        logic src_a;
        logic snk_a;
        logic src_b;
        logic snk_b;
    } gate_t;

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
    parameter int PERIOD_CYC  = 1000,
    parameter int NUM_BRIDGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_i,
    output logic [NUM_BRIDGES-1:0] cycle_start_o
);
    localparam int CW      = $clog2(PERIOD_CYC);
    localparam int STAGGER = PERIOD_CYC / NUM_BRIDGES;

    logic [CW-1:0] cnt;

    // Counter wraps at PERIOD_CYC; sleep holds it at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (sleep_i)
            cnt <= '0;
        else if (cnt == CW'(PERIOD_CYC - 1))
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    // Each bridge gets its own start point, evenly spread across the period.
    for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_start
        assign cycle_start_o[i] = !sleep_i && (cnt == CW'(i * STAGGER));
    end

endmodule

// File: rtl/chop_bridge_fsm.sv
module chop_bridge_fsm
    import chop_pwm_pkg::*;
#(
    parameter int DEAD_CYC  = 43,
    parameter int BLANK_CYC = 60
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  kill_i,
    input  logic  phase_i,
    input  logic  trip_i,
    input  logic  cycle_start_i,
    output gate_t gate_o
);
    localparam int MAXC = (DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    bridge_state_e state, state_nxt;
    logic [TW-1:0] tcnt, tcnt_nxt;
    logic          dir, dir_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            tcnt  <= '0;
            dir   <= 1'b1;
        end else begin
            state <= state_nxt;
            tcnt  <= tcnt_nxt;
            dir   <= dir_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        tcnt_nxt  = tcnt;
        dir_nxt   = dir;
        if (kill_i) begin
            state_nxt = ST_OFF;
            tcnt_nxt  = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (cycle_start_i) begin
                        state_nxt = ST_DEAD;
                        tcnt_nxt  = '0;
                        dir_nxt   = phase_i;
                    end
                end
                ST_DEAD: begin
                    dir_nxt = phase_i;
                    if (tcnt == TW'(DEAD_CYC - 1)) begin
                        state_nxt = ST_BLANK;
                        tcnt_nxt  = '0;
                    end else begin
                        tcnt_nxt = tcnt + TW'(1);
                    end
                end
                ST_BLANK: begin
                    if (phase_i != dir) begin
                        state_nxt = ST_DEAD;
                        tcnt_nxt  = '0;
                        dir_nxt   = phase_i;
                    end else if (tcnt == TW'(BLANK_CYC - 1)) begin
                        state_nxt = ST_DRIVE;
                        tcnt_nxt  = '0;
                    end else begin
                        tcnt_nxt = tcnt + TW'(1);
                    end
                end
                ST_DRIVE: begin
                    if (phase_i != dir) begin
                        state_nxt = ST_DEAD;
                        tcnt_nxt  = '0;
                        dir_nxt   = phase_i;
                    end else if (trip_i) begin
                        state_nxt = ST_DECAY;
                    end
                end
                ST_DECAY: begin
                    if (phase_i != dir) begin
                        state_nxt = ST_DEAD;
                        tcnt_nxt  = '0;
                        dir_nxt   = phase_i;
                    end else if (cycle_start_i) begin
                        state_nxt = ST_BLANK;
                        tcnt_nxt  = '0;
                    end
                end
                default: begin
                    state_nxt = ST_OFF;
                    tcnt_nxt  = '0;
                end
            endcase
        end
    end

    // Outputs from the state register only
    always_comb begin
        logic src_on, snk_on;
        src_on = 1'b0;
        snk_on = 1'b0;
        unique case (state)
            ST_BLANK, ST_DRIVE: begin
                src_on = 1'b1;
                snk_on = 1'b1;
            end
            ST_DECAY: snk_on = 1'b1;
            default: begin
                src_on = 1'b0;
                snk_on = 1'b0;
            end
        endcase
        gate_o.src_a = src_on &  dir;
        gate_o.snk_b = snk_on &  dir;
        gate_o.src_b = src_on & ~dir;
        gate_o.snk_a = snk_on & ~dir;
    end

endmodule

// File: rtl/chop_pwm_ctrl.sv
module chop_pwm_ctrl
    import chop_pwm_pkg::*;
#(
    parameter int NUM_BRIDGES = 2,
    parameter int PERIOD_CYC  = 1000,
    parameter int DEAD_CYC    = 43,
    parameter int BLANK_CYC   = 60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_i,
    input  logic                   fault_i,
    input  logic [NUM_BRIDGES-1:0] phase_i,
    input  logic [NUM_BRIDGES-1:0] enable_i,
    input  logic [NUM_BRIDGES-1:0] trip_i,
    output logic [NUM_BRIDGES-1:0] src_a_o,
    output logic [NUM_BRIDGES-1:0] snk_a_o,
    output logic [NUM_BRIDGES-1:0] src_b_o,
    output logic [NUM_BRIDGES-1:0] snk_b_o
);
    logic [NUM_BRIDGES-1:0] cycle_start;
    gate_t                  gates [NUM_BRIDGES];

    chop_period_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .NUM_BRIDGES(NUM_BRIDGES)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .cycle_start_o(cycle_start)
    );

    for (genvar i = 0; i < NUM_BRIDGES; i++) begin : g_bridge
        chop_bridge_fsm #(
            .DEAD_CYC (DEAD_CYC),
            .BLANK_CYC(BLANK_CYC)
        ) fsm_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .kill_i       (sleep_i | fault_i | ~enable_i[i]),
            .phase_i      (phase_i[i]),
            .trip_i       (trip_i[i]),
            .cycle_start_i(cycle_start[i]),
            .gate_o       (gates[i])
        );
        assign src_a_o[i] = gates[i].src_a;
        assign snk_a_o[i] = gates[i].snk_a;
        assign src_b_o[i] = gates[i].src_b;
        assign snk_b_o[i] = gates[i].snk_b;
    end

endmodule

// File: rtl/chop_pwm_ctrl_chk.sv
module chop_pwm_ctrl_chk #(
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_i,
    input logic          fault_i,
    input logic [NB-1:0] phase_i,
    input logic [NB-1:0] enable_i,
    input logic [NB-1:0] src_a_o,
    input logic [NB-1:0] snk_a_o,
    input logic [NB-1:0] src_b_o,
    input logic [NB-1:0] snk_b_o
);
    logic any_on;
    assign any_on = |{src_a_o, snk_a_o, src_b_o, snk_b_o};

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !any_on);

    assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !any_on);

    for (genvar i = 0; i < NB; i++) begin : g_chk
        assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(src_a_o[i] && snk_a_o[i]) && !(src_b_o[i] && snk_b_o[i]));

        assert_no_direct_reverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (src_b_o[i] || snk_a_o[i]) |-> !$past(src_a_o[i] || snk_b_o[i]));

        assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !enable_i[i] |=> !(src_a_o[i] || snk_a_o[i] || src_b_o[i] || snk_b_o[i]));

        assert_blank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(src_a_o[i]) && enable_i[i] && phase_i[i] && !fault_i && !sleep_i)
            |=> src_a_o[i]);

        assert_decay_sink_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(src_a_o[i]) && $past(enable_i[i] && phase_i[i] && !fault_i && !sleep_i))
            |-> snk_b_o[i]);
    end

endmodule

bind chop_pwm_ctrl chop_pwm_ctrl_chk #(.NB(NUM_BRIDGES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_i (sleep_i),
    .fault_i (fault_i),
    .phase_i (phase_i),
    .enable_i(enable_i),
    .src_a_o (src_a_o),
    .snk_a_o (snk_a_o),
    .src_b_o (src_b_o),
    .snk_b_o (snk_b_o)
);

// File: tb/chop_pwm_ctrl_tb_top.sv
module chop_pwm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 40;
    localparam int STAG = P / 2;
    localparam int D    = 3;
    localparam int B    = 4;

    // Nibble per bridge: {src_a, snk_a, src_b, snk_b}
    localparam logic [3:0] FWD   = 4'b1001;
    localparam logic [3:0] REV   = 4'b0110;
    localparam logic [3:0] DEC_F = 4'b0001;
    localparam logic [3:0] DEC_R = 4'b0100;
    localparam logic [3:0] NONE  = 4'b0000;

    typedef struct {
        int         c;
        logic [7:0] mask;
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       fault_i = 1'b0;
    logic [1:0] phase_i = 2'b11;
    logic [1:0] enable_i = 2'b00;
    logic [1:0] trip_i = 2'b00;
    logic [1:0] src_a_o, snk_a_o, src_b_o, snk_b_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   overlap_cnt = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chop_pwm_ctrl #(
        .NUM_BRIDGES(2),
        .PERIOD_CYC (P),
        .DEAD_CYC   (D),
        .BLANK_CYC  (B)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .fault_i (fault_i),
        .phase_i (phase_i),
        .enable_i(enable_i),
        .trip_i  (trip_i),
        .src_a_o (src_a_o),
        .snk_a_o (snk_a_o),
        .src_b_o (src_b_o),
        .snk_b_o (snk_b_o)
    );

    function automatic logic [7:0] outs();
        return {src_a_o[1], snk_a_o[1], src_b_o[1], snk_b_o[1],
                src_a_o[0], snk_a_o[0], src_b_o[0], snk_b_o[0]};
    endfunction

    // Driver side: push an expectation for bridge b (0, 1, or 2 = both)
    task automatic expect_at(input int c, input int b, input logic [3:0] nib, input string req);
        exp_t e;
        e.c    = c;
        e.mask = (b == 0) ? 8'h0F : (b == 1) ? 8'hF0 : 8'hFF;
        e.val  = {nib, nib} & e.mask;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compare outputs against due expectations, watch for overlap
    always @(negedge clk) begin
        logic [7:0] o;
        o = outs();
        if (rst_n && (((src_a_o & snk_a_o) | (src_b_o & snk_b_o)) != 2'b00))
            overlap_cnt++;
        for (int k = exp_q.size() - 1; k >= 0; k--) begin
            if (exp_q[k].c <= cyc) begin
                checks++;
                if (exp_q[k].c < cyc || (o & exp_q[k].mask) != exp_q[k].val) begin
                    errors++;
                    $display("FAIL %s cyc=%0d actual=%h expected=%h",
                             exp_q[k].req, cyc, o & exp_q[k].mask, exp_q[k].val);
                end
                exp_q.delete(k);
            end
        end
    end

    initial begin
        int c0;
        int c5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_at(cyc + 2, 2, NONE, "R1 reset state");

        // Sleep, then release: start-up sequence with trip held high
        wait_until(cyc + 3);
        sleep_i  = 1'b1;
        enable_i = 2'b11;
        phase_i  = 2'b11;
        trip_i   = 2'b11;
        wait_until(cyc + 3);
        c0 = cyc;
        sleep_i = 1'b0;
        expect_at(c0 + D,             0, NONE,  "R3 dead gap before first turn-on");
        expect_at(c0 + D + 1,         0, FWD,   "R10 turn-on after sleep release");
        expect_at(c0 + D + 1,         1, NONE,  "R6 bridge1 not yet on");
        expect_at(c0 + D + 1 + B,     0, FWD,   "R4 source held through blanking");
        expect_at(c0 + D + 2 + B,     0, DEC_F, "R5 trip after blank, sink stays");
        expect_at(c0 + STAG + D,      1, NONE,  "R6 bridge1 still off");
        expect_at(c0 + STAG + D + 1,  1, FWD,   "R6 bridge1 offset turn-on");
        expect_at(c0 + P,             0, DEC_F, "R5 decay until cycle start");
        expect_at(c0 + P + 1,         0, FWD,   "R5 restart after one period");
        expect_at(c0 + P + STAG,      1, DEC_F, "R6 bridge1 decay");
        expect_at(c0 + P + STAG + 1,  1, FWD,   "R6 half-period offset steady state");
        wait_until(c0 + P + STAG + 5);
        trip_i = 2'b00;

        // Trip pulse inside blanking ignored, then real trip
        wait_until(c0 + 2 * P + 1);
        trip_i[0] = 1'b1;
        wait_until(c0 + 2 * P + 3);
        trip_i[0] = 1'b0;
        expect_at(c0 + 2 * P + 7,  0, FWD, "R4 pulse in blank ignored");
        wait_until(c0 + 2 * P + 10);
        trip_i[0] = 1'b1;
        expect_at(c0 + 2 * P + 10, 0, FWD,   "R5 source on before trip");
        expect_at(c0 + 2 * P + 11, 0, DEC_F, "R5 one-clock trip latency");
        wait_until(c0 + 2 * P + 11);
        trip_i[0] = 1'b0;

        // Direction change on bridge1 during DRIVE
        wait_until(c0 + 104);
        phase_i[1] = 1'b0;
        expect_at(c0 + 105, 1, NONE, "R7 dead gap first clock");
        expect_at(c0 + 107, 1, NONE, "R7 dead gap last clock");
        expect_at(c0 + 108, 1, REV,  "R2 reverse direction drivers");
        wait_until(c0 + 108);
        trip_i[1] = 1'b1;
        expect_at(c0 + 112, 1, REV,   "R7 new blanking window");
        expect_at(c0 + 113, 1, DEC_R, "R7 trip after new blank");
        wait_until(c0 + 114);
        trip_i[1] = 1'b0;

        // Enable drop on bridge0
        wait_until(c0 + 130);
        expect_at(c0 + 130, 0, FWD, "R8 bridge0 driving before enable drop");
        enable_i[0] = 1'b0;
        expect_at(c0 + 131, 0, NONE,  "R8 enable low turns bridge off");
        expect_at(c0 + 131, 1, DEC_R, "R8 other bridge unaffected");
        wait_until(c0 + 132);
        enable_i[0] = 1'b1;
        expect_at(c0 + 150, 0, NONE, "R8 waits for cycle start");
        expect_at(c0 + 163, 0, NONE, "R3 dead gap after restart");
        expect_at(c0 + 164, 0, FWD,  "R3 turn-on after dead gap");

        // Fault
        wait_until(c0 + 170);
        fault_i = 1'b1;
        expect_at(c0 + 171, 2, NONE, "R9 fault turns all off");
        wait_until(c0 + 185);
        fault_i = 1'b0;
        expect_at(c0 + 200, 2, NONE, "R9 off until cycle start");
        expect_at(c0 + 204, 0, FWD,  "R9 bridge0 resumes");
        expect_at(c0 + 223, 1, NONE, "R9 bridge1 waits own start");
        expect_at(c0 + 224, 1, REV,  "R9 bridge1 resumes reversed");

        // Sleep mid-operation, counter restart
        wait_until(c0 + 230);
        sleep_i = 1'b1;
        expect_at(c0 + 231, 2, NONE, "R10 sleep turns all off");
        wait_until(c0 + 236);
        c5 = cyc;
        sleep_i = 1'b0;
        expect_at(c5 + D,            0, NONE, "R10 dead gap after wake");
        expect_at(c5 + D + 1,        0, FWD,  "R10 counter restarted from zero");
        expect_at(c5 + STAG + D,     1, NONE, "R6 bridge1 off before offset");
        expect_at(c5 + STAG + D + 1, 1, REV,  "R6 bridge1 offset after wake");

        wait_until(c5 + STAG + D + 4);
        checks++;
        if (overlap_cnt != 0) begin
            errors++;
            $display("FAIL R7 same-side overlap actual=%0d expected=0", overlap_cnt);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL all-reqs pending expectations actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule